// File: doc/BRIEF.md
# Triggered Four-Level Address Sequencer

The sequencer walks one nested copy descriptor and emits a stream of burst requests, each one naming a read address, a write address and a byte length. Both the read side and the write side have their own origin, their own loop limits at four depths and their own signed strides at depths one to three. The innermost depth is a contiguous byte run, so every request covers exactly that many bytes. The number of requests in a transfer is the product of the read-side limits at depths one, two and three. The write side advances once per request through its own nest. When it has stepped through all of its positions it starts again at its origin.

A transfer is launched by a one-cycle `start` with every parameter valid. Starting can be immediate or gated. With both trigger selects off, bursts flow at once. With a trigger select on, every gate pulse releases one depth-2 step of the read nest, which is depth-1 limit bursts, and the block then parks until the next release. Pulses that arrive early are held in a small saturating counter. Notification is a one-cycle `evt`, raised either once at the end or after each depth-2 step.

The control is a three-state machine. `ST_IDLE` goes to `ST_BURST` on `start` when no trigger is selected, and to `ST_WAIT` when one is. An empty descriptor on `start` keeps it in `ST_IDLE`. `ST_WAIT` goes to `ST_BURST` once every selected gate holds a pulse. `ST_BURST` goes to `ST_IDLE` on the accepted final burst. It goes to `ST_WAIT` on an accepted burst that closes a depth-2 step while gating is on. Otherwise it stays in `ST_BURST`.

Top module: `nd_xfer_seq`

## Requirements
- R1: After reset, `busy`, `req_valid` and `evt` are 0.
- R2: Burst n of the read side has address `src_base + k1*S1 + k2*S2 + k3*S3`. Here k1, k2 and k3 are the depth-1/2/3 indices in that nesting order, with depth 1 fastest, and S are the signed 32-bit strides. Strides are packed in `src_dim` as depth d at bits `[(d-1)*32 +: 32]`. Addresses wrap modulo 2^32.
- R3: The write side follows the same formula with its own origin, limits and strides, stepping once per accepted burst. A zero stride at a depth returns the address to that depth's enclosing base on every iteration. After its last position it restarts at `dst_base`.
- R4: `req_bytes` equals the read depth-0 limit, up to 65535. Limits are 16-bit unsigned, packed in `src_cnt`/`dst_cnt` with depth d at bits `[d*16 +: 16]`.
- R5: With both trigger selects 0, `req_valid` is 1 in the cycle after `start`. Exactly the product of the read depth-1..3 limits bursts are issued.
- R6: With a trigger select at 1, no burst is offered until a pulse has been taken. Each taken pulse releases exactly the read depth-1 limit bursts, and then `req_valid` drops.
- R7: Pulses arriving while a step is running are kept, up to 3 outstanding, and each later releases one step.
- R8: A trigger input whose select is 0 has no effect. When both selects are 1, a step needs a pulse on each.
- R9: With `evt_sel`=0, `evt` is high for exactly one cycle, the cycle after the final burst is accepted.
- R10: With `evt_sel`=1, `evt` is high in the cycle after each accepted burst that closes a depth-2 step, including the last.
- R11: If any of the eight limits is 0, `start` yields `evt` in the next cycle, no burst, and `busy` stays 0.
- R12: `busy` is 1 from the cycle after `start` until the cycle after the final burst is accepted. A `start` while busy is ignored.
- R13: While `req_valid` is 1 and `req_ready` is 0, the request fields hold and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch pulse, parameters valid |
| trig0_sel | input | 1 | 1: gate on trig0 |
| trig1_sel | input | 1 | 1: gate on trig1 |
| evt_sel | input | 1 | 0: event at end, 1: event per depth-2 step |
| src_base | input | AW | Read origin |
| src_cnt | input | 4*CW | Read limits, depths 0..3 |
| src_dim | input | 96 | Read strides, depths 1..3 |
| dst_base | input | AW | Write origin |
| dst_cnt | input | 4*CW | Write limits, depths 0..3 |
| dst_dim | input | 96 | Write strides, depths 1..3 |
| trig0 | input | 1 | Gate pulse 0 |
| trig1 | input | 1 | Gate pulse 1 |
| req_valid | output | 1 | Burst request offered |
| req_ready | input | 1 | Burst request accepted |
| req_src | output | AW | Burst read address |
| req_dst | output | AW | Burst write address |
| req_bytes | output | CW | Burst byte length |
| busy | output | 1 | Transfer in progress |
| evt | output | 1 | Completion or step event |

## Verification
The bench aims at depth rollover with negative and zero strides. A sequencer that measured strides from the last address instead of the enclosing base would drift there. It also runs a write nest whose shape differs from the read nest, which catches a shared counter. Gating is probed with early and back-to-back pulses and with noise on an unselected trigger. A lost pending pulse would hang the run, and an ignored select would let bursts out before their release. Random back-pressure checks that nothing advances while stalled. An empty descriptor, a 65535-byte run and a restart attempt mid-transfer cover the remaining edges.

// File: rtl/nd_seq_pkg.sv
package nd_seq_pkg;
    localparam int DIM_W = 32;
    localparam int NEST_D = 3;
    localparam int NTRIG = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } seq_state_e;

    typedef enum logic {
        EVT_END  = 1'b0,
        EVT_STEP = 1'b1
    } evt_mode_e;
endpackage

// File: rtl/nd_addr_nest.sv
module nd_addr_nest
    import nd_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    input  logic [AW-1:0]             origin,
    input  logic [NEST_D*CW-1:0]      lim_in,
    input  logic [NEST_D*DIM_W-1:0]   dim_in,
    output logic [AW-1:0]             addr,
    output logic [NEST_D-1:0]         at_end
);
    logic [CW-1:0]           last_q [NEST_D];
    logic [CW-1:0]           idx_q  [NEST_D];
    logic signed [DIM_W-1:0] dim_q  [NEST_D];
    logic [AW-1:0]           origin_q, base3_q, base2_q, cur_q;
    logic [AW-1:0]           next2, next3;

    function automatic logic [AW-1:0] widen(input logic signed [DIM_W-1:0] d);
        return AW'(d);
    endfunction

    for (genvar g = 0; g < NEST_D; g++) begin : g_end
        assign at_end[g] = (idx_q[g] == last_q[g]);
    end

    assign next2 = base2_q + widen(dim_q[1]);
    assign next3 = base3_q + widen(dim_q[2]);
    assign addr  = cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            origin_q <= '0;
            base3_q  <= '0;
            base2_q  <= '0;
            cur_q    <= '0;
            for (int i = 0; i < NEST_D; i++) begin
                last_q[i] <= '0;
                idx_q[i]  <= '0;
                dim_q[i]  <= '0;
            end
        end else if (load) begin
            origin_q <= origin;
            base3_q  <= origin;
            base2_q  <= origin;
            cur_q    <= origin;
            for (int i = 0; i < NEST_D; i++) begin
                last_q[i] <= lim_in[i*CW +: CW] - CW'(1);
                idx_q[i]  <= '0;
                dim_q[i]  <= dim_in[i*DIM_W +: DIM_W];
            end
        end else if (step) begin
            if (!at_end[0]) begin
                idx_q[0] <= idx_q[0] + CW'(1);
                cur_q    <= cur_q + widen(dim_q[0]);
            end else if (!at_end[1]) begin
                idx_q[0] <= '0;
                idx_q[1] <= idx_q[1] + CW'(1);
                base2_q  <= next2;
                cur_q    <= next2;
            end else if (!at_end[2]) begin
                idx_q[0] <= '0;
                idx_q[1] <= '0;
                idx_q[2] <= idx_q[2] + CW'(1);
                base3_q  <= next3;
                base2_q  <= next3;
                cur_q    <= next3;
            end else begin
                for (int i = 0; i < NEST_D; i++) idx_q[i] <= '0;
                base3_q <= origin_q;
                base2_q <= origin_q;
                cur_q   <= origin_q;
            end
        end
    end

    // R2
    load_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(origin));

    // R3
    wrap_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && (&at_end) |=> addr == origin_q);

    // R2
    inner_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && !at_end[0] |=> addr == $past(addr) + widen(dim_q[0]));
endmodule

// File: rtl/nd_trig_gate.sv
module nd_trig_gate #(
    parameter int PW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic enable,
    input  logic pulse,
    input  logic take,
    output logic armed
);
    localparam logic [PW-1:0] PMAX = '1;

    logic [PW-1:0] pend_q;
    logic          inc, dec;

    assign armed = (pend_q != '0);
    assign dec   = take && armed;
    assign inc   = enable && pulse && ((pend_q != PMAX) || dec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (clr) begin
            pend_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   pend_q <= pend_q + PW'(1);
                2'b01:   pend_q <= pend_q - PW'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    // R7
    pulse_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && pulse && !take && !clr && (pend_q != PMAX) |=> pend_q == $past(pend_q) + PW'(1));

    // R8
    masked_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !take && !clr |=> $stable(pend_q));
endmodule

// File: rtl/nd_xfer_seq.sv
module nd_xfer_seq
    import nd_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int PW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   trig0_sel,
    input  logic                   trig1_sel,
    input  logic                   evt_sel,
    input  logic [AW-1:0]          src_base,
    input  logic [4*CW-1:0]        src_cnt,
    input  logic [3*DIM_W-1:0]     src_dim,
    input  logic [AW-1:0]          dst_base,
    input  logic [4*CW-1:0]        dst_cnt,
    input  logic [3*DIM_W-1:0]     dst_dim,
    input  logic                   trig0,
    input  logic                   trig1,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [AW-1:0]          req_src,
    output logic [AW-1:0]          req_dst,
    output logic [CW-1:0]          req_bytes,
    output logic                   busy,
    output logic                   evt
);
    seq_state_e        state_q, state_d;
    evt_mode_e         emode_q;
    logic [CW-1:0]     len_q;
    logic [NTRIG-1:0]  tsel_q, armed, take, pulses;
    logic [AW-1:0]     dst_origin_q, src_addr, dst_addr;
    logic [NEST_D-1:0] src_end, dst_end;
    logic              evt_q, evt_d;
    logic              launch, empty, hs, gated, go, row_done, all_done;

    assign launch   = (state_q == ST_IDLE) && start;
    assign hs       = (state_q == ST_BURST) && req_ready;
    assign gated    = |tsel_q;
    assign go       = &(armed | ~tsel_q);
    assign row_done = src_end[0];
    assign all_done = &src_end;
    assign pulses   = {trig1, trig0};

    always_comb begin
        empty = 1'b0;
        for (int d = 0; d < 4; d++) begin
            if (src_cnt[d*CW +: CW] == '0) empty = 1'b1;
            if (dst_cnt[d*CW +: CW] == '0) empty = 1'b1;
        end
    end

    nd_addr_nest #(.AW(AW), .CW(CW)) u_src_nest (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .step   (hs),
        .origin (src_base),
        .lim_in (src_cnt[4*CW-1:CW]),
        .dim_in (src_dim),
        .addr   (src_addr),
        .at_end (src_end)
    );

    nd_addr_nest #(.AW(AW), .CW(CW)) u_dst_nest (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .step   (hs),
        .origin (dst_base),
        .lim_in (dst_cnt[4*CW-1:CW]),
        .dim_in (dst_dim),
        .addr   (dst_addr),
        .at_end (dst_end)
    );

    for (genvar g = 0; g < NTRIG; g++) begin : g_gate
        assign take[g] = (state_q == ST_WAIT) && go && tsel_q[g];
        nd_trig_gate #(.PW(PW)) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (launch),
            .enable (tsel_q[g]),
            .pulse  (pulses[g]),
            .take   (take[g]),
            .armed  (armed[g])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch && !empty)
                    state_d = (trig0_sel || trig1_sel) ? ST_WAIT : ST_BURST;
            end
            ST_WAIT: begin
                if (go) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (hs) begin
                    if (all_done)               state_d = ST_IDLE;
                    else if (row_done && gated) state_d = ST_WAIT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid = (state_q == ST_BURST);
        busy      = (state_q != ST_IDLE);
        req_src   = src_addr;
        req_dst   = dst_addr;
        req_bytes = len_q;
        evt       = evt_q;
        evt_d     = (launch && empty)
                 || (hs && all_done)
                 || (hs && row_done && (emode_q == EVT_STEP));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            evt_q        <= 1'b0;
            len_q        <= '0;
            tsel_q       <= '0;
            emode_q      <= EVT_END;
            dst_origin_q <= '0;
        end else begin
            state_q <= state_d;
            evt_q   <= evt_d;
            if (launch) begin
                len_q        <= src_cnt[CW-1:0];
                tsel_q       <= {trig1_sel, trig0_sel};
                emode_q      <= evt_mode_e'(evt_sel);
                dst_origin_q <= dst_base;
            end
        end
    end

    // R13
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_bytes));

    // R12
    final_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs && all_done |=> !busy && evt);

    // R11
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch && empty |=> evt && !busy);

    // R6
    step_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs && row_done && !all_done && gated |=> !req_valid && busy);

    // R3
    dst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs && (&dst_end) |=> req_dst == dst_origin_q);

    // R5
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !empty && !trig0_sel && !trig1_sel |=> req_valid);
endmodule

// File: tb/tb_nd_xfer_seq.sv
module tb_nd_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, trig0_sel = 1'b0, trig1_sel = 1'b0, evt_sel = 1'b0;
    logic [31:0] src_base = '0, dst_base = '0;
    logic [63:0] src_cnt = '0, dst_cnt = '0;
    logic [95:0] src_dim = '0, dst_dim = '0;
    logic        trig0 = 1'b0, trig1 = 1'b0, req_ready = 1'b0;
    logic        req_valid, busy, evt;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_bytes;

    int checks = 0;
    int errors = 0;
    int sc[4], dc[4], sd[3], dd[3];

    always #10 clk = ~clk;

    nd_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .trig0_sel(trig0_sel), .trig1_sel(trig1_sel), .evt_sel(evt_sel),
        .src_base(src_base), .src_cnt(src_cnt), .src_dim(src_dim),
        .dst_base(dst_base), .dst_cnt(dst_cnt), .dst_dim(dst_dim),
        .trig0(trig0), .trig1(trig1),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_bytes(req_bytes),
        .busy(busy), .evt(evt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] place(input logic [31:0] b, input int k1, input int k2, input int k3,
                                          input int d1, input int d2, input int d3);
        return b + 32'(k1 * d1 + k2 * d2 + k3 * d3);
    endfunction

    task automatic pack();
        src_cnt = {16'(sc[3]), 16'(sc[2]), 16'(sc[1]), 16'(sc[0])};
        dst_cnt = {16'(dc[3]), 16'(dc[2]), 16'(dc[1]), 16'(dc[0])};
        src_dim = {32'(sd[2]), 32'(sd[1]), 32'(sd[0])};
        dst_dim = {32'(dd[2]), 32'(dd[1]), 32'(dd[0])};
    endtask

    task automatic run_case(input bit t0, input bit t1, input bit em, input bit restart_mid);
        int k1 = 0, k2 = 0, k3 = 0, j1 = 0, j2 = 0, j3 = 0;
        int bursts = 0, sent0 = 0, sent1 = 0, cyc = 0;
        int total, steps;
        bit exp_evt = 0, gated, first = 1;
        gated = t0 || t1;
        total = sc[1] * sc[2] * sc[3];
        steps = sc[2] * sc[3];
        pack();
        trig0_sel = t0; trig1_sel = t1; evt_sel = em;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R12: busy right after launch
        chk(busy == 1'b1, "R12 busy after start", 32'(busy), 1);
        while (bursts < total && cyc < 20000) begin
            bit hs, nx;
            int rel;
            chk(evt == exp_evt, em ? "R10 step event" : "R9 end event", 32'(evt), 32'(exp_evt));
            rel = (t0 && t1) ? ((sent0 < sent1) ? sent0 : sent1) : (t0 ? sent0 : sent1);
            if (gated && req_valid && bursts >= rel * sc[1])
                chk(0, "R6 burst before release", bursts, rel * sc[1]);
            if (first && !gated) chk(req_valid == 1'b1, "R5 immediate start", 32'(req_valid), 1);
            first = 0;
            req_ready = ($urandom % 4) != 0;
            trig0 = t0 && sent0 < steps && (sent0 - bursts / sc[1]) < 2 && ($urandom % 3 == 0);
            trig1 = t1 ? (sent1 < steps && (sent1 - bursts / sc[1]) < 2 && ($urandom % 3 == 0))
                       : (($urandom % 2) == 0);
            start = restart_mid && (bursts == total / 2);
            hs = req_valid && req_ready;
            nx = 0;
            if (hs) begin
                chk(req_src == place(src_base, k1, k2, k3, sd[0], sd[1], sd[2]), "R2 src address",
                    req_src, place(src_base, k1, k2, k3, sd[0], sd[1], sd[2]));
                chk(req_dst == place(dst_base, j1, j2, j3, dd[0], dd[1], dd[2]), "R3 dst address",
                    req_dst, place(dst_base, j1, j2, j3, dd[0], dd[1], dd[2]));
                chk(req_bytes == 16'(sc[0]), "R4 byte length", 32'(req_bytes), sc[0]);
                nx = (bursts + 1 == total) || (em && k1 == sc[1] - 1);
                bursts++;
                if (k1 < sc[1] - 1) k1++;
                else begin k1 = 0; if (k2 < sc[2] - 1) k2++; else begin k2 = 0; k3++; end end
                if (j1 < dc[1] - 1) j1++;
                else begin
                    j1 = 0;
                    if (j2 < dc[2] - 1) j2++;
                    else begin j2 = 0; if (j3 < dc[3] - 1) j3++; else j3 = 0; end
                end
            end
            exp_evt = nx;
            if (trig0) sent0++;
            if (t1 && trig1) sent1++;
            cyc++;
            @(negedge clk);
        end
        if (cyc >= 20000) chk(0, "R7 progress lost", bursts, total);
        req_ready = 1'b0; trig0 = 1'b0; trig1 = 1'b0; start = 1'b0;
        chk(evt == exp_evt, "R9 final event", 32'(evt), 32'(exp_evt));
        chk(busy == 1'b0, "R12 busy cleared", 32'(busy), 0);
        @(negedge clk);
        chk(evt == 1'b0, "R9 single pulse", 32'(evt), 0);
        chk(req_valid == 1'b0, "R12 no extra burst", 32'(req_valid), 0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2025));
        repeat (3) @(negedge clk);
        // R1
        chk(busy == 1'b0 && req_valid == 1'b0 && evt == 1'b0, "R1 reset state",
            {29'd0, busy, req_valid, evt}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // staged buffer: 32x4 runs into a 128-byte window, per-step release and events
        sc = '{32, 4, 10, 1}; dc = '{32, 4, 10, 1};
        sd = '{32, 128, 1280}; dd = '{32, 0, 0};
        src_base = 32'h1000; dst_base = 32'h8000;
        run_case(1, 0, 1, 0);

        // free running with negative strides, end event, restart attempt mid-way (R12)
        sc = '{8, 3, 2, 2}; dc = '{8, 2, 3, 2};
        sd = '{-16, 100, -7}; dd = '{4, -40, 0};
        src_base = 32'h10; dst_base = 32'hFFFF_FFF0;
        run_case(0, 0, 0, 1);

        // both gates selected (R8)
        sc = '{4, 2, 3, 2}; dc = '{4, 3, 2, 2};
        sd = '{8, 64, 512}; dd = '{8, 24, 0};
        src_base = 32'h2000; dst_base = 32'h3000;
        run_case(1, 1, 1, 0);

        // maximum level-0 length (R4)
        sc = '{65535, 1, 1, 1}; dc = '{65535, 1, 1, 1};
        sd = '{0, 0, 0}; dd = '{0, 0, 0};
        src_base = 32'hABCD_0000; dst_base = 32'h1234_0000;
        run_case(0, 0, 0, 0);

        for (int n = 0; n < 12; n++) begin
            for (int d = 0; d < 4; d++) begin
                sc[d] = (d == 0) ? 1 + $urandom % 64 : 1 + $urandom % 4;
                dc[d] = (d == 0) ? 1 + $urandom % 64 : 1 + $urandom % 4;
            end
            for (int d = 0; d < 3; d++) begin
                sd[d] = int'($urandom % 129) - 64;
                dd[d] = int'($urandom % 129) - 64;
            end
            src_base = $urandom; dst_base = $urandom;
            run_case(n % 3 == 1, n % 4 == 3, n % 2 == 1, 0);
        end

        // empty descriptor (R11)
        sc = '{16, 2, 0, 1}; dc = '{16, 2, 2, 1};
        pack();
        trig0_sel = 1'b0; trig1_sel = 1'b0; evt_sel = 1'b0;
        req_ready = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(evt == 1'b1, "R11 empty event", 32'(evt), 1);
        chk(busy == 1'b0, "R11 empty not busy", 32'(busy), 0);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(req_valid == 1'b0, "R11 no burst", 32'(req_valid), 0);
        end
        req_ready = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule